// File: doc/BRIEF.md
# Programmable Frequency Output Divider

The block produces a square wave on an output pin whose rate software picks in two steps. A 2-bit source code selects one of four timing strobes, the fastest derived from a 32768 Hz base and the others at 1024 Hz, 32 Hz and 1 Hz. A 3-bit ratio code then divides that source by 1, 2, 3, 6, 5, 10, 15 or 30. Each ratio carries a fixed duty cycle of 50 %, 33 % or 20 %.

The block runs on one fast system clock. Each source arrives as a single-cycle strobe that marks every edge of that source's square wave, so there are two strobes per source period. A single wrapping counter walks through one output period, which is twice the ratio in strobes. The wave is high for the leading part of that period.

An output enable holds the wave low. A separate pin enable drives the tri-state control and the pin value, and it is independent of any register access. A change of either select field restarts the period at its start, so a new frequency begins with a full high phase.

Top module: `prog_freq_divider`

## Requirements
- R1: `src_sel` picks the strobe that advances the output: 00 `tick_base`, 01 `tick_mid`, 10 `tick_low`, 11 `tick_sec`. Each strobe marks one half period of its source, so one output period spans 2×ratio strobes of the selected input.
- R2: `div_sel` codes 000 to 111 give ratios 1, 2, 3, 6, 5, 10, 15 and 30. The output period is therefore 2, 4, 6, 12, 10, 20, 30 and 60 strobe intervals.
- R3: The output is high for the first H strobe intervals of each period. H is 1, 2, 2, 6, 2, 10, 10 and 30 for codes 000 to 111, which gives 50 %, 50 %, 33 %, 50 %, 20 %, 50 %, 33 % and 50 % duty. With selects and enables steady, the output changes only in the cycle after a selected strobe.
- R4: While `out_en` is 0, `freq_o` is 0 from the next cycle on and the period counter is held at its start.
- R5: `freq_oe` equals `pin_en` in the same cycle. `freq_o` is 0 whenever `pin_en` is 0.
- R6: When `src_sel` or `div_sel` differs from its value in the previous cycle and `out_en` is 1, the period restarts. `freq_o` is then 1 in the next cycle if `pin_en` is 1.
- R7: During reset (`rst_n` low) `freq_o` is 0, and `freq_oe` still follows `pin_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than every strobe |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_base | input | 1 | Edge strobe of the 32768 Hz source |
| tick_mid | input | 1 | Edge strobe of the 1024 Hz source |
| tick_low | input | 1 | Edge strobe of the 32 Hz source |
| tick_sec | input | 1 | Edge strobe of the 1 Hz source |
| out_en | input | 1 | Frequency output enable; 0 holds the wave low |
| src_sel | input | 2 | Source select code |
| div_sel | input | 3 | Ratio select code |
| pin_en | input | 1 | Secondary pin enable driving the tri-state control |
| freq_o | output | 1 | Square-wave output value |
| freq_oe | output | 1 | Output enable for the pad driver; 0 means high impedance |

## Verification
The bench builds the block with the package defaults, which size the period counter for the longest 60-strobe period. It drives the four strobes at fixed spacings of 2, 5, 7 and 11 clocks in place of their real rates. With those spacings every ratio and every source shows whole periods within a few hundred cycles. The distinct spacings let a measured period tell a wrong source apart from a wrong ratio, and the 11-clock spacing shows that the output stays level between strobes.

// File: rtl/fdiv_pkg.sv
// Package: shared types and ratio/duty decoding for the frequency divider.
// Assumes the period counter covers the longest period of 60 strobe intervals.
package fdiv_pkg;
    localparam int SRC_W      = 2;
    localparam int DIV_W      = 3;
    localparam int NUM_SRC    = 1 << SRC_W;
    localparam int MAX_PERIOD = 60;
    localparam int CNT_W      = $clog2(MAX_PERIOD);

    typedef logic [CNT_W-1:0] cnt_t;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic [DIV_W-1:0] div;
    } sel_t;

    // Division ratio for each ratio code
    function automatic int ratio_of(logic [DIV_W-1:0] code);
        case (code)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 3;
            3'd3:    return 6;
            3'd4:    return 5;
            3'd5:    return 10;
            3'd6:    return 15;
            default: return 30;
        endcase
    endfunction

    // Last counter index of one output period (2*ratio strobes)
    function automatic cnt_t last_idx(logic [DIV_W-1:0] code);
        return cnt_t'(2 * ratio_of(code) - 1);
    endfunction

    // Number of strobe intervals the wave stays high in one period
    function automatic cnt_t high_len(logic [DIV_W-1:0] code);
        int r;
        r = ratio_of(code);
        case (code)
            3'd2, 3'd6: return cnt_t'((2 * r) / 3);
            3'd4:       return cnt_t'((2 * r) / 5);
            default:    return cnt_t'(r);
        endcase
    endfunction
endpackage

// File: rtl/fdiv_src_mux.sv
// Module: picks the strobe of the selected source.
// Assumes each strobe input is a single-cycle pulse synchronous to clk.
module fdiv_src_mux
    import fdiv_pkg::*;
(
    input  logic [NUM_SRC-1:0] ticks,
    input  logic [SRC_W-1:0]   src,
    output logic               strobe
);
    // Select one strobe by source code
    always_comb begin
        strobe = ticks[src];
    end
endmodule

// File: rtl/fdiv_core.sv
// Module: period counter and wave level for the chosen ratio.
// Assumes the strobe is already selected; a select change or a cleared
// enable restarts the period at index zero.
module fdiv_core
    import fdiv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic out_en,
    input  sel_t sel_in,
    output logic level
);
    sel_t sel_q;
    logic en_q;
    cnt_t cnt;
    logic restart;

    // Restart on a select change or while the output is disabled
    always_comb begin
        restart = (sel_in != sel_q) || !out_en;
    end

    // Track the selects and the enable for change detection and gating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            en_q  <= 1'b0;
        end else begin
            sel_q <= sel_in;
            en_q  <= out_en;
        end
    end

    // Walk through one output period, one step per selected strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (strobe) begin
            cnt <= (cnt == last_idx(sel_q.div)) ? '0 : cnt + 1'b1;
        end
    end

    // High for the leading part of the period
    always_comb begin
        level = en_q && (cnt < high_len(sel_q.div));
    end
endmodule

// File: rtl/fdiv_pin.sv
// Module: gates the wave with the secondary pin enable.
// Assumes the pad is driven only while the pin enable is high.
module fdiv_pin (
    input  logic level,
    input  logic pin_en,
    output logic pin_val,
    output logic pin_oe
);
    // Drive the pad control and force the value low when released
    always_comb begin
        pin_oe  = pin_en;
        pin_val = pin_en & level;
    end
endmodule

// File: rtl/prog_freq_divider.sv
// Module: programmable frequency output divider, top level.
// Assumes the source strobes mark each half period of their sources and
// that clk is fast enough for two strobes never to fall in one cycle of
// the same source.
module prog_freq_divider
    import fdiv_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_base,
    input  logic             tick_mid,
    input  logic             tick_low,
    input  logic             tick_sec,
    input  logic             out_en,
    input  logic [SRC_W-1:0] src_sel,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             pin_en,
    output logic             freq_o,
    output logic             freq_oe
);
    logic [NUM_SRC-1:0] ticks;
    logic               strobe;
    logic               level;
    sel_t               sel_in;

    // Gather strobes in source-code order and pack the selects
    always_comb begin
        ticks      = {tick_sec, tick_low, tick_mid, tick_base};
        sel_in.src = src_sel;
        sel_in.div = div_sel;
    end

    fdiv_src_mux u_mux (
        .ticks  (ticks),
        .src    (src_sel),
        .strobe (strobe)
    );

    fdiv_core u_core (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .out_en (out_en),
        .sel_in (sel_in),
        .level  (level)
    );

    fdiv_pin u_pin (
        .level   (level),
        .pin_en  (pin_en),
        .pin_val (freq_o),
        .pin_oe  (freq_oe)
    );
endmodule

// File: rtl/fdiv_checker.sv
// Module: property checker bound to the divider top level.
// Assumes it sees only the top-level ports.
module fdiv_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_base,
    input logic       tick_mid,
    input logic       tick_low,
    input logic       tick_sec,
    input logic       out_en,
    input logic [1:0] src_sel,
    input logic [2:0] div_sel,
    input logic       pin_en,
    input logic       freq_o,
    input logic       freq_oe
);
    logic past_ok;
    logic sel_strobe;

    // Mark that one clean cycle out of reset has passed
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // Strobe of the currently selected source, seen from the ports
    always_comb begin
        case (src_sel)
            2'd0:    sel_strobe = tick_base;
            2'd1:    sel_strobe = tick_mid;
            2'd2:    sel_strobe = tick_low;
            default: sel_strobe = tick_sec;
        endcase
    end

    AST_OE_GATES_VALUE: assert property (@(posedge clk)
        !freq_oe |-> !freq_o); // R5

    AST_LOW_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !freq_o); // R4

    AST_CLEAN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && out_en && !$stable({src_sel, div_sel}))
        |=> (freq_o || !freq_oe)); // R6

    AST_STEADY_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !sel_strobe && out_en && $past(out_en) && $stable({src_sel, div_sel}))
        |=> ($stable(freq_o) || !$stable(pin_en))); // R3
endmodule

bind prog_freq_divider fdiv_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_base (tick_base),
    .tick_mid  (tick_mid),
    .tick_low  (tick_low),
    .tick_sec  (tick_sec),
    .out_en    (out_en),
    .src_sel   (src_sel),
    .div_sel   (div_sel),
    .pin_en    (pin_en),
    .freq_o    (freq_o),
    .freq_oe   (freq_oe)
);

// File: tb/prog_freq_divider_tb.sv
`timescale 1ns/1ps
// Bench: directed scenarios for the programmable frequency output divider.
module prog_freq_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       out_en = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [2:0] div_sel = 3'd0;
    logic       pin_en = 1'b1;
    logic       freq_o, freq_oe;
    logic       tick_base, tick_mid, tick_low, tick_sec;
    int         tc = 0;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    localparam int SP_BASE = 2;
    localparam int SP_MID  = 5;
    localparam int SP_LOW  = 7;
    localparam int SP_SEC  = 11;

    always #2.5 clk = ~clk;

    // Free-running strobe generator with distinct spacings per source
    always @(posedge clk) tc <= tc + 1;
    assign tick_base = (tc % SP_BASE) == 0;
    assign tick_mid  = (tc % SP_MID)  == 0;
    assign tick_low  = (tc % SP_LOW)  == 0;
    assign tick_sec  = (tc % SP_SEC)  == 0;

    prog_freq_divider u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_base (tick_base),
        .tick_mid  (tick_mid),
        .tick_low  (tick_low),
        .tick_sec  (tick_sec),
        .out_en    (out_en),
        .src_sel   (src_sel),
        .div_sel   (div_sel),
        .pin_en    (pin_en),
        .freq_o    (freq_o),
        .freq_oe   (freq_oe)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected ratio and high length from the requirement tables
    function automatic int exp_ratio(input int code);
        int r[8] = '{1, 2, 3, 6, 5, 10, 15, 30};
        return r[code];
    endfunction

    function automatic int exp_high(input int code);
        int h[8] = '{1, 2, 2, 6, 2, 10, 10, 30};
        return h[code];
    endfunction

    // Skip two rising edges, then measure one full period in clock cycles
    task automatic measure(output int per, output int hi, output bit ok);
        int  guard = 0;
        int  seen = 0;
        bit  prev;
        ok = 1'b0; per = 0; hi = 0;
        @(negedge clk); prev = freq_o;
        while (seen < 2 && guard < 4000) begin
            @(negedge clk); guard++;
            if (freq_o && !prev) seen++;
            prev = freq_o;
        end
        if (seen < 2) return;
        per = 1; hi = 1; guard = 0;
        while (guard < 4000) begin
            @(negedge clk); guard++;
            if (freq_o && !prev) begin
                ok = 1'b1;
                break;
            end
            prev = freq_o;
            per++;
            if (freq_o) hi++;
        end
    endtask

    // R7: outputs while held in reset
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(freq_o == 1'b0, "R7", "freq_o in reset", freq_o, 0);
        check(freq_oe == 1'b1, "R7", "freq_oe in reset", freq_oe, 1);
        rst_n = 1'b1;
        out_en = 1'b1;
    endtask

    // R2, R3: every ratio on the base source
    task automatic t_ratios();
        int per, hi;
        bit ok;
        for (int code = 0; code < 8; code++) begin
            @(negedge clk);
            src_sel = 2'd0;
            div_sel = 3'(code);
            measure(per, hi, ok);
            check(ok && per == 2 * exp_ratio(code) * SP_BASE, "R2", "period cycles",
                  per, 2 * exp_ratio(code) * SP_BASE);
            check(ok && hi == exp_high(code) * SP_BASE, "R3", "high cycles",
                  hi, exp_high(code) * SP_BASE);
        end
    endtask

    // R1: each slower source with ratio code 001 (period 4 strobes)
    task automatic t_sources();
        int per, hi;
        bit ok;
        int sp[4] = '{SP_BASE, SP_MID, SP_LOW, SP_SEC};
        for (int s = 1; s < 4; s++) begin
            @(negedge clk);
            src_sel = 2'(s);
            div_sel = 3'd1;
            measure(per, hi, ok);
            check(ok && per == 4 * sp[s], "R1", "source period cycles", per, 4 * sp[s]);
        end
        @(negedge clk);
        src_sel = 2'd3;
        div_sel = 3'd0;
        measure(per, hi, ok);
        check(ok && hi == SP_SEC && per == 2 * SP_SEC, "R3", "slow ratio-1 high cycles",
              hi, SP_SEC);
    endtask

    // R4: output enable cleared holds the wave low
    task automatic t_disable();
        int bad = 0;
        @(negedge clk);
        src_sel = 2'd0;
        div_sel = 3'd0;
        out_en = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (freq_o) bad++;
        end
        check(bad == 0, "R4", "high samples while disabled", bad, 0);
        out_en = 1'b1;
        @(negedge clk);
        check(freq_o == 1'b1, "R4", "first level after enable", freq_o, 1);
    endtask

    // R5: pin enable released forces high impedance and a low value
    task automatic t_pin();
        int bad = 0;
        @(negedge clk);
        pin_en = 1'b0;
        for (int i = 0; i < 30; i++) begin
            if (freq_oe || freq_o) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R5", "driven samples while deselected", bad, 0);
        pin_en = 1'b1;
        #1;
        check(freq_oe == 1'b1, "R5", "freq_oe after reselect", freq_oe, 1);
    endtask

    // R6: a select change restarts the period with a high phase
    task automatic t_restart();
        int guard = 0;
        @(negedge clk);
        src_sel = 2'd0;
        div_sel = 3'd4;
        repeat (4) @(negedge clk);
        while (freq_o && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(freq_o == 1'b0, "R6", "low before change", freq_o, 0);
        div_sel = 3'd6;
        @(negedge clk);
        check(freq_o == 1'b1, "R6", "high after select change", freq_o, 1);
    endtask

    initial begin
        t_reset();
        t_ratios();
        t_sources();
        t_disable();
        t_pin();
        t_restart();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run ends as a failed check
    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule